// File: doc/BRIEF.md
# MDIO Management Master with Access and Data Registers

This block lets a host read and write the internal registers of external Ethernet PHYs over the two-wire MDC/MDIO management bus. The host sees two registers through a simple word-indexed write port and a combinational read port. The first is a 32-bit command register that holds the PHY address, the register index, the transfer direction and a busy flag. The second is a 16-bit data register.

Writing the command register starts one standard clause-22 frame. It also sets the busy flag at once. The flag clears by itself after the frame has ended and MDIO has been released. While busy is set, every host write is dropped, so the data register stays stable for an outgoing write. For a read, the data register takes the sampled PHY data in the same cycle that busy clears.

MDC is made from the system clock by a parameterised divider. MDIO changes only while MDC is low, and read data is sampled on the rising MDC edge.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command register (index 0) and the data register (index 1) both read 0, MDC is low and MDIO output-enable is low.
- R2: A host write to index 0 while idle makes bit 0 (busy) read 1 from the next cycle on and starts a frame. Bit 0 of the written value is ignored.
- R3: Command register layout: bits 15:11 hold the PHY address, bits 10:6 hold the register index, and bit 1 selects the direction (1 = write to the PHY, 0 = read). Bits 31:16 and 5:2 read 0 and ignore writes.
- R4: The data register reads in bits 15:0 with bits 31:16 as 0. Indices other than 0 and 1 read 0.
- R5: A write frame is 64 bits sent MSB first, all driven: 32 ones, 01, opcode 01, the 5-bit address, the 5-bit index, turnaround 10, then the 16 data bits.
- R6: A read frame drives 32 ones, 01, opcode 10, the address and the index. It then releases MDIO (output-enable low, MDIO output high) for the 2 turnaround bits and the 16 data bits. The data is sampled on rising MDC, MSB first, and is readable in the data register once busy reads 0.
- R7: MDC has a period of 2*CLK_DIV system clocks during a frame and stays low when idle. The MDIO output and the output-enable change only while MDC is low.
- R8: After the last bit, MDIO is released at least one system cycle before busy clears.
- R9: Host writes to either register while busy is 1 are ignored and do not alter the frame in progress. This includes a write in the last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | ADDR_W | Host register word index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two events can fall in the same cycle: busy clearing at the end of a frame, and a host write arriving. The bench provokes this by polling each cycle during a write frame. In the first cycle where MDIO is released, it checks that busy still reads 1 and then issues a data-register write in that same cycle. It then expects busy to read 0, the data register to hold its old value, and no new frame to appear on MDC.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int PHY_AW    = 5;
    localparam int REG_AW    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    // first bit position that is released on a read (turnaround)
    localparam int RD_REL    = FRAME_LEN - DATA_W - 2;
    localparam int RD_DATA   = FRAME_LEN - DATA_W;

    typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_FIN} eng_state_t;

    typedef struct packed {
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] idx;
        logic              wr;
    } cmd_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int CLK_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } cg_t;

    cg_t s_q, s_d;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = en && (s_q.cnt == CNT_LAST);
        if (!en) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = !s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc  = s_q.mdc;
    assign rise = wrap && !s_q.mdc;
    assign fall = wrap &&  s_q.mdc;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              run,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        eng_state_t           st;
        logic [IDX_W-1:0]     bit_n;
        logic [FRAME_LEN-1:0] sh;
        logic                 oe;
        logic                 is_rd;
        logic [DATA_W-1:0]    rd;
    } eng_t;

    eng_t s_q, s_d;
    logic [FRAME_LEN-1:0] frame;

    always_comb begin
        frame = {{PRE_LEN{1'b1}}, 2'b01,
                 cmd.wr ? 2'b01 : 2'b10,
                 cmd.phy, cmd.idx,
                 cmd.wr ? {2'b10, wdata} : {(DATA_W+2){1'b1}}};
        s_d = s_q;
        case (s_q.st)
            ENG_IDLE: begin
                if (start) begin
                    s_d.st    = ENG_RUN;
                    s_d.bit_n = '0;
                    s_d.sh    = frame;
                    s_d.oe    = 1'b1;
                    s_d.is_rd = !cmd.wr;
                end
            end
            ENG_RUN: begin
                if (rise && s_q.is_rd && (s_q.bit_n >= IDX_W'(RD_DATA)))
                    s_d.rd = {s_q.rd[DATA_W-2:0], mdio_i};
                if (fall) begin
                    if (s_q.bit_n == IDX_W'(FRAME_LEN - 1)) begin
                        s_d.st = ENG_FIN;
                        s_d.oe = 1'b0;
                        s_d.sh = '1;
                    end else begin
                        s_d.bit_n = s_q.bit_n + 1'b1;
                        s_d.sh    = {s_q.sh[FRAME_LEN-2:0], 1'b1};
                        s_d.oe    = !(s_q.is_rd &&
                                      (s_q.bit_n + 1'b1 >= IDX_W'(RD_REL)));
                    end
                end
            end
            default: s_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.sh <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign run     = (s_q.st == ENG_RUN);
    assign done    = (s_q.st == ENG_FIN);
    assign mdio_o  = s_q.sh[FRAME_LEN-1];
    assign mdio_oe = s_q.oe;
    assign rd_data = s_q.rd;
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output cmd_t              cmd,
    output logic              busy,
    output logic [DATA_W-1:0] data_val
);
    localparam logic [ADDR_W-1:0] IDX_CMD  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] IDX_DATA = ADDR_W'(1);

    typedef struct packed {
        cmd_t              cmd;
        logic              busy;
        logic              start;
        logic [DATA_W-1:0] data;
    } rf_t;

    rf_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (done) begin
            s_d.busy = 1'b0;
            if (!s_q.cmd.wr) s_d.data = rd_data;
        end
        if (reg_wr && !s_q.busy) begin
            if (reg_addr == IDX_CMD) begin
                s_d.cmd.phy = reg_wdata[15:11];
                s_d.cmd.idx = reg_wdata[10:6];
                s_d.cmd.wr  = reg_wdata[1];
                s_d.busy    = 1'b1;
                s_d.start   = 1'b1;
            end else if (reg_addr == IDX_DATA) begin
                s_d.data = reg_wdata[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == IDX_CMD)
            reg_rdata = {16'b0, s_q.cmd.phy, s_q.cmd.idx, 4'b0, s_q.cmd.wr, s_q.busy};
        else if (reg_addr == IDX_DATA)
            reg_rdata = {16'b0, s_q.data};
    end

    assign start    = s_q.start;
    assign cmd      = s_q.cmd;
    assign busy     = s_q.busy;
    assign data_val = s_q.data;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int CLK_DIV = 10,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              start, done, run, rise, fall, busy;
    cmd_t              cmd;
    logic [DATA_W-1:0] data_val, rd_data;

    mdio_reg_file #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
        .rd_data(rd_data), .start(start), .cmd(cmd), .busy(busy),
        .data_val(data_val)
    );

    mdio_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(run), .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .wdata(data_val),
        .rise(rise), .fall(fall), .mdio_i(mdio_i), .run(run), .done(done),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
    );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              done,
    input logic [15:0]       data_val
);
    // R7
    mdio_o_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);
    // R7
    mdio_oe_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> !mdc);
    // R8
    release_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(!mdio_oe) && $past(mdio_o)));
    // R2
    busy_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && reg_addr == '0) |=> busy);
    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(data_val));
    // R7
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !mdc);
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
    .done(done), .data_val(data_val)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
    localparam int PERIOD = 10;
    localparam int DIV    = 2;
    localparam int AW     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mdc, mdio_o, mdio_oe;
    logic          mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    logic [63:0] cap_bits, cap_oe;
    int          rise_cnt = 0;
    logic [15:0] resp = '0;
    time         last_rise = 0;
    time         mdc_per = 0;

    always #(PERIOD/2) clk = !clk;

    mdio_mgmt_master #(.CLK_DIV(DIV), .ADDR_W(AW)) u_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // simple PHY model
    always @(posedge mdc) begin
        cap_bits  <= {cap_bits[62:0], mdio_o};
        cap_oe    <= {cap_oe[62:0], mdio_oe};
        rise_cnt  <= rise_cnt + 1;
        if (last_rise != 0) mdc_per <= $time - last_rise;
        last_rise <= $time;
    end
    always @(negedge mdc) begin
        if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i <= resp[63 - rise_cnt];
        else                                   mdio_i <= 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            @(negedge clk);
            host_rd(0, v);
            n++;
        end while (v[0] && n < 5000);
    endtask

    task automatic arm_phy(input logic [15:0] r);
        @(negedge clk);
        rise_cnt = 0; resp = r; last_rise = 0;
    endtask

    function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                             input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        host_rd(0, v); check(v == 0, "R1 cmd reg", v, 0);
        host_rd(1, v); check(v == 0, "R1 data reg", v, 0);
        check(!mdc && !mdio_oe, "R1 line idle", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        arm_phy(16'h0);
        host_wr(1, 32'h0000_A5C3);
        host_wr(0, {16'h0, 5'h0B, 5'h12, 4'h0, 1'b1, 1'b0});
        host_rd(0, v);
        check(v[0] == 1'b1, "R2 busy set", v, 1);
        wait_idle();
        check(rise_cnt == 64, "R5 bit count", rise_cnt, 64);
        check(cap_bits == wr_frame(5'h0B, 5'h12, 16'hA5C3), "R5 write frame",
              cap_bits, wr_frame(5'h0B, 5'h12, 16'hA5C3));
        check(cap_oe == '1, "R5 write driven", cap_oe, '1);
        check(mdc_per == 2*DIV*PERIOD, "R7 mdc period", mdc_per, 2*DIV*PERIOD);
        check(!mdc, "R7 mdc idle low", mdc, 0);
    endtask

    task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        logic [31:0] v;
        logic [63:0] exp_b, exp_oe;
        arm_phy(d);
        host_wr(0, {16'h0, p, r, 4'h0, 1'b0, 1'b0});
        wait_idle();
        exp_b  = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h3FFFF};
        exp_oe = {46'h3FFF_FFFF_FFFF, 18'h0};
        check(cap_bits == exp_b, "R6 read header", cap_bits, exp_b);
        check(cap_oe == exp_oe, "R6 read release", cap_oe, exp_oe);
        host_rd(1, v);
        check(v == {16'h0, d}, "R6 read data", v, {16'h0, d});
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        arm_phy(16'h0);
        host_wr(1, 32'h0000_1357);
        host_wr(0, {16'h0, 5'h03, 5'h04, 4'h0, 1'b1, 1'b0});
        host_wr(1, 32'h0000_FFFF);
        host_wr(0, {16'h0, 5'h1F, 5'h1F, 4'h0, 1'b0, 1'b0});
        wait_idle();
        check(cap_bits == wr_frame(5'h03, 5'h04, 16'h1357), "R9 frame undisturbed",
              cap_bits, wr_frame(5'h03, 5'h04, 16'h1357));
        host_rd(1, v); check(v == 32'h1357, "R9 data kept", v, 32'h1357);
        host_rd(0, v);
        check(v == {16'h0, 5'h03, 5'h04, 6'b000010}, "R9 cmd kept", v,
              {16'h0, 5'h03, 5'h04, 6'b000010});
    endtask

    task automatic t_last_cycle();
        logic [31:0] v;
        bit seen_oe = 0;
        int n = 0;
        arm_phy(16'h0);
        host_wr(1, 32'h0000_2468);
        host_wr(0, {16'h0, 5'h01, 5'h02, 4'h0, 1'b1, 1'b0});
        forever begin
            @(negedge clk);
            n++;
            if (mdio_oe) seen_oe = 1;
            if ((seen_oe && !mdio_oe) || n > 5000) break;
        end
        host_rd(0, v);
        check(v[0] == 1'b1, "R8 busy after release", v, 1);
        check(mdio_o == 1'b1, "R8 released high", mdio_o, 1);
        reg_addr = 1; reg_wdata = 32'h0000_BEEF; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        host_rd(0, v); check(v[0] == 1'b0, "R9 busy cleared", v, 0);
        host_rd(1, v); check(v == 32'h2468, "R9 last-cycle write dropped", v, 32'h2468);
        repeat (20) @(negedge clk);
        check(rise_cnt == 64, "R9 no new frame", rise_cnt, 64);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        arm_phy(16'h0);
        host_wr(1, 32'hABCD_1234);
        host_rd(1, v); check(v == 32'h0000_1234, "R4 data upper zero", v, 32'h1234);
        host_rd(2, v); check(v == 0, "R4 unused index", v, 0);
        host_wr(0, 32'hFFFF_FFFF);
        host_rd(0, v); check(v == 32'h0000_FFC3, "R3 reserved masked busy", v, 32'hFFC3);
        wait_idle();
        host_rd(0, v); check(v == 32'h0000_FFC2, "R3 fields after frame", v, 32'hFFC2);
        check(cap_bits == wr_frame(5'h1F, 5'h1F, 16'h1234), "R3 field to frame",
              cap_bits, wr_frame(5'h1F, 5'h1F, 16'h1234));
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_read(5'h15, 5'h0A, 16'hC35A);
        t_read(5'h00, 5'h1F, 16'h8001);
        t_busy_ignore();
        t_last_cycle();
        t_fields();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule